// File: doc/BRIEF.md
# Scan Test Mode Controller

This controller sequences the at-speed test of a register-heavy die from a handful of slow external pins. It runs on the falling edge of the high-speed test clock. A scan request holds it in a shift state, where the scan chain is closed and the core is shielded from the bits moving through it. When the request is released, the controller steps through three falling edges: it opens the chain and picks the input source, then presents the stored pattern and starts a sample window, then ends the window so that the sampling cells capture. It then parks in a done state until the next scan request.

A mode pin is latched while scan is held. It chooses between a single-shot test, where one sample pulse is issued, and continuous operation, where an on-chip pattern generator is enabled instead. A configuration input picks whether the input cells take their data from the scan latches (die test) or from the pads (trace test on the module). A clear pulse for the write-capture latch is issued on entry to the done state, so that no runt write pulse starts the next test. When the test-enable pin is low, the decoded outputs are forced, combinationally, into normal operation.

Top module: `scan_mode_ctrl`

## Requirements
- R1: A synchronous active-high reset on a falling clock edge puts the controller in the shift state: with test enabled, close_chain_o=1, present_o=0, sample_o=0, sel_scan_o=0, wcap_clr_o=0, cont_run_o=0.
- R2: While test_en_i is 0, present_o=1 and sel_scan_o=0 (pads), and close_chain_o, sample_o, wcap_clr_o and cont_run_o are 0, without waiting for a clock edge and whatever the other inputs are.
- R3: scan_i high at any falling edge puts the controller in the shift state, from any state, with the chain closed and present_o low.
- R4: At the first falling edge with scan_i low after the shift state, the controller enters the run state: close_chain_o=0, present_o=0, sample_o=0.
- R5: At the next falling edge it enters the shot state: present_o=1, and sample_o=1 when single-shot mode was latched.
- R6: At the next falling edge it enters the done state: sample_o=0 and present_o=1. It stays there while scan_i stays low.
- R7: wcap_clr_o is 1 for exactly CLR_CYCLES cycles starting at entry to the done state, and ends at once if scan_i takes the controller out of that state.
- R8: The mode pin ss_i is latched at every falling edge with scan_i high; changes of ss_i after scan_i falls have no effect. In continuous mode (latched ss_i=0), cont_run_o=1 in the shot and done states and sample_o stays 0.
- R9: Outside the shift state, sel_scan_o follows die_test_i (1 selects the scan latches, 0 selects the pads); in the shift state sel_scan_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | High-speed test clock; state changes on its falling edge |
| rst | input | 1 | Synchronous active-high reset |
| scan_i | input | 1 | Scan request; holds the controller in the shift state |
| ss_i | input | 1 | Mode select: 1 single-shot, 0 continuous |
| test_en_i | input | 1 | Test enable; 0 forces normal operation asynchronously |
| die_test_i | input | 1 | 1 for die test (scan-latch inputs), 0 for trace test (pad inputs) |
| close_chain_o | output | 1 | Close the scan chain so cells shift from their neighbour |
| present_o | output | 1 | Open the input latches to present the pattern to the core |
| sample_o | output | 1 | Sample window; its falling edge triggers capture |
| sel_scan_o | output | 1 | Input-source select: 1 scan latches, 0 pads |
| wcap_clr_o | output | 1 | Clear for the write-capture latch |
| cont_run_o | output | 1 | Enable for the continuous pattern generator |

## Verification
The bench builds the controller with CLR_CYCLES set to 2 instead of the default 1, so the clear pulse spans more than one cycle and the count-down of the clear window can be observed and cut short by a scan request in its middle. It then walks both test modes with each setting of the die-test bit, toggles the mode pin after scan falls, drops test enable in mid-sequence, and resets from the done state, comparing every output against a behavioural model on every clock.

// File: rtl/stc_pkg.sv
package stc_pkg;

    typedef enum logic [1:0] {
        ST_SCAN = 2'd0,
        ST_RUN  = 2'd1,
        ST_SHOT = 2'd2,
        ST_DONE = 2'd3
    } stc_state_e;

    typedef struct packed {
        logic close_chain;
        logic present;
        logic sample;
        logic sel_scan;
        logic wcap_clr;
        logic cont_run;
    } stc_ctl_t;

    localparam stc_ctl_t CTL_NORMAL = '{close_chain: 1'b0, present: 1'b1, sample: 1'b0,
                                        sel_scan: 1'b0, wcap_clr: 1'b0, cont_run: 1'b0};

    // Step of the test sequence when no scan request is present.
    function automatic stc_state_e stc_advance(input stc_state_e s);
        case (s)
            ST_SCAN: return ST_RUN;
            ST_RUN:  return ST_SHOT;
            default: return ST_DONE;
        endcase
    endfunction

endpackage

// File: rtl/stc_sequencer.sv
module stc_sequencer
    import stc_pkg::*;
#(
    parameter int unsigned CLR_CYCLES = 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scan_i,
    input  logic       ss_i,
    output stc_state_e state_o,
    output logic       single_o,
    output logic       clr_active_o
);
    localparam int unsigned CW = $clog2(CLR_CYCLES + 1);

    stc_state_e    state;
    logic          ss_q;
    logic [CW-1:0] clr_cnt;

    always_ff @(negedge clk) begin
        if (rst) begin
            state   <= ST_SCAN;
            ss_q    <= 1'b0;
            clr_cnt <= '0;
        end else if (scan_i) begin
            state   <= ST_SCAN;
            ss_q    <= ss_i;
            clr_cnt <= '0;
        end else begin
            state <= stc_advance(state);
            if (state == ST_SHOT)
                clr_cnt <= CW'(CLR_CYCLES);
            else if (clr_cnt != '0)
                clr_cnt <= clr_cnt - 1'b1;
        end
    end

    assign state_o      = state;
    assign single_o     = ss_q;
    assign clr_active_o = (clr_cnt != '0);

    // R3: a scan request always lands in the shift state
    assert_scan_enters_R3: assert property (@(negedge clk) disable iff (rst)
        scan_i |=> state == ST_SCAN);

    // R6: done state is held while scan stays low
    assert_done_holds_R6: assert property (@(negedge clk) disable iff (rst)
        (state == ST_DONE && !scan_i) |=> state == ST_DONE);

    // R7: the clear window opens full on entry to done
    assert_clr_load_R7: assert property (@(negedge clk) disable iff (rst)
        (state == ST_DONE && $past(state) == ST_SHOT) |-> clr_cnt == CW'(CLR_CYCLES));

    // R8: latched mode is frozen once scan is released
    assert_mode_frozen_R8: assert property (@(negedge clk) disable iff (rst)
        !scan_i |=> $stable(ss_q));

endmodule

// File: rtl/stc_decoder.sv
module stc_decoder
    import stc_pkg::*;
(
    input  stc_state_e state_i,
    input  logic       single_i,
    input  logic       clr_active_i,
    input  logic       die_test_i,
    output stc_ctl_t   ctl_o
);
    always_comb begin
        ctl_o = '0;
        case (state_i)
            ST_SCAN: begin
                ctl_o.close_chain = 1'b1;
            end
            ST_RUN: begin
                ctl_o.sel_scan = die_test_i;
            end
            ST_SHOT: begin
                ctl_o.sel_scan = die_test_i;
                ctl_o.present  = 1'b1;
                ctl_o.sample   = single_i;
                ctl_o.cont_run = !single_i;
            end
            default: begin
                ctl_o.sel_scan = die_test_i;
                ctl_o.present  = 1'b1;
                ctl_o.cont_run = !single_i;
                ctl_o.wcap_clr = clr_active_i;
            end
        endcase
    end
endmodule

// File: rtl/stc_override.sv
module stc_override
    import stc_pkg::*;
(
    input  logic     test_en_i,
    input  stc_ctl_t ctl_i,
    output stc_ctl_t ctl_o
);
    assign ctl_o = test_en_i ? ctl_i : CTL_NORMAL;
endmodule

// File: rtl/scan_mode_ctrl.sv
module scan_mode_ctrl
    import stc_pkg::*;
#(
    parameter int unsigned CLR_CYCLES = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic scan_i,
    input  logic ss_i,
    input  logic test_en_i,
    input  logic die_test_i,
    output logic close_chain_o,
    output logic present_o,
    output logic sample_o,
    output logic sel_scan_o,
    output logic wcap_clr_o,
    output logic cont_run_o
);
    stc_state_e state;
    logic       single;
    logic       clr_active;
    stc_ctl_t   ctl_dec;
    stc_ctl_t   ctl_out;

    stc_sequencer #(.CLR_CYCLES(CLR_CYCLES)) u_seq (
        .clk          (clk),
        .rst          (rst),
        .scan_i       (scan_i),
        .ss_i         (ss_i),
        .state_o      (state),
        .single_o     (single),
        .clr_active_o (clr_active)
    );

    stc_decoder u_dec (
        .state_i      (state),
        .single_i     (single),
        .clr_active_i (clr_active),
        .die_test_i   (die_test_i),
        .ctl_o        (ctl_dec)
    );

    stc_override u_ovr (
        .test_en_i (test_en_i),
        .ctl_i     (ctl_dec),
        .ctl_o     (ctl_out)
    );

    assign close_chain_o = ctl_out.close_chain;
    assign present_o     = ctl_out.present;
    assign sample_o      = ctl_out.sample;
    assign sel_scan_o    = ctl_out.sel_scan;
    assign wcap_clr_o    = ctl_out.wcap_clr;
    assign cont_run_o    = ctl_out.cont_run;

    // R2: normal mode keeps the core fed from the pads
    assert_normal_mode_R2: assert property (@(negedge clk) disable iff (rst)
        !test_en_i |-> (present_o && !sel_scan_o && !sample_o));

    // R3: a closed chain never coincides with pattern presentation
    assert_chain_shield_R3: assert property (@(negedge clk) disable iff (rst)
        (close_chain_o && test_en_i) |-> !present_o);

    // R5: the sample window lasts a single cycle
    assert_sample_single_R5: assert property (@(negedge clk) disable iff (rst)
        (sample_o && test_en_i) |=> !sample_o);

    // R8: sampling and continuous running are exclusive
    assert_mode_exclusive_R8: assert property (@(negedge clk) disable iff (rst)
        !(sample_o && cont_run_o));

endmodule

// File: tb/scan_mode_ctrl_bench.sv
module scan_mode_ctrl_bench;
    localparam int CLR = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scan = 1'b1, ss = 1'b1, test_en = 1'b1, die = 1'b1;
    logic cc, pp, ps, sel, clr, cont;

    int compared = 0;
    int mismatched = 0;
    bit finished = 1'b0;

    scan_mode_ctrl #(.CLR_CYCLES(CLR)) u_scan_mode_ctrl (
        .clk(clk), .rst(rst), .scan_i(scan), .ss_i(ss), .test_en_i(test_en),
        .die_test_i(die), .close_chain_o(cc), .present_o(pp), .sample_o(ps),
        .sel_scan_o(sel), .wcap_clr_o(clr), .cont_run_o(cont)
    );

    always #2 clk = ~clk;

    // Behavioural reference: phase 0 shift, 1 run, 2 shot, 3 done.
    int  m_phase = 0;
    bit  m_single = 0;
    int  m_clr = 0;
    bit  m_valid = 0;
    bit  m_from_rst = 0;

    always @(negedge clk) begin
        m_valid = 1'b1;
        m_from_rst = rst;
        if (rst) begin
            m_phase = 0; m_single = 0; m_clr = 0;
        end else if (scan) begin
            m_phase = 0; m_single = ss; m_clr = 0;
        end else if (m_phase < 3) begin
            m_phase = m_phase + 1;
            if (m_phase == 3) m_clr = CLR;
        end else if (m_clr > 0) begin
            m_clr = m_clr - 1;
        end
    end

    function automatic string tag_for(int fld);
        if (!test_en) return "R2";
        if (fld == 3) return "R9";
        case (m_phase)
            0: return m_from_rst ? "R1" : "R3";
            1: return "R4";
            2: return (fld == 5 || (fld == 2 && !m_single)) ? "R8" : "R5";
            default: return (fld == 4) ? "R7" : ((fld == 5) ? "R8" : "R6");
        endcase
    endfunction

    task automatic cmp(input int fld, input logic act, input logic exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s field %0d phase %0d: actual %b expected %b at %0t",
                     tag_for(fld), fld, m_phase, act, exp, $time);
        end
    endtask

    task automatic check_all();
        logic [5:0] e;
        if (!m_valid) return;
        if (!test_en) e = 6'b010000;
        else begin
            e = '0;
            case (m_phase)
                0: e[5] = 1'b1;
                1: e[2] = die;
                2: begin e[4] = 1'b1; e[3] = m_single; e[2] = die; e[0] = !m_single; end
                default: begin
                    e[4] = 1'b1; e[2] = die; e[0] = !m_single; e[1] = (m_clr > 0);
                end
            endcase
        end
        cmp(0, cc,   e[5]);
        cmp(1, pp,   e[4]);
        cmp(2, ps,   e[3]);
        cmp(3, sel,  e[2]);
        cmp(4, clr,  e[1]);
        cmp(5, cont, e[0]);
    endtask

    task automatic cyc(input logic r, input logic sc, input logic s,
                       input logic t, input logic d, input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            rst = r; scan = sc; ss = s; test_en = t; die = d;
            #1;
            check_all();
        end
    endtask

    initial begin
        // R1: reset state with scan requested
        cyc(1, 1, 1, 1, 1, 3);
        // R3 shift, then R4, R5, R6, R7 single-shot die test
        cyc(0, 1, 1, 1, 1, 2);
        cyc(0, 0, 1, 1, 1, 7);
        // R8: continuous mode latched, ss toggled after scan falls
        cyc(0, 1, 0, 1, 1, 2);
        cyc(0, 0, 1, 1, 1, 3);
        cyc(0, 0, 0, 1, 1, 2);
        cyc(0, 0, 1, 1, 1, 3);
        // R9: trace test picks the pads in every state
        cyc(0, 1, 1, 1, 0, 2);
        cyc(0, 0, 1, 1, 0, 6);
        // R9: die-test bit followed live in done
        cyc(0, 0, 1, 1, 1, 2);
        // R2: normal override in mid-sequence with varied inputs
        cyc(0, 1, 1, 0, 1, 2);
        cyc(0, 0, 1, 0, 1, 1);
        cyc(0, 0, 0, 1, 1, 1);
        cyc(0, 0, 1, 0, 0, 2);
        cyc(0, 0, 1, 1, 1, 3);
        // R7: scan rises inside the clear window and cuts it short
        cyc(0, 1, 1, 1, 1, 2);
        cyc(0, 0, 1, 1, 1, 3);
        cyc(0, 1, 1, 1, 1, 2);
        cyc(0, 0, 1, 1, 1, 6);
        // R1: reset from the done state, then R3 scan right after
        cyc(1, 0, 1, 1, 1, 2);
        cyc(0, 0, 0, 1, 1, 4);
        cyc(0, 1, 0, 1, 0, 1);
        cyc(0, 0, 0, 1, 0, 5);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!finished) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule